// File: doc/BRIEF.md
# Dual-Load Update Interval Counter

This block is a binary down counter that paces the update strobe of a waveform generator. It times both the steady interval between updates and the delay from a start trigger to the first update. It holds two writable load values, a primary and a secondary. A selection policy decides which of the two supplies each reload. The policy can change the selection on stop events, on buffer-complete events, or on the counter's own terminal count. This lets the first period after a trigger, or the period after a buffer ends, differ from the steady interval.

The counter advances once per chosen edge of an external source level that has already been selected. The source is sampled in the block's clock domain and a polarity input picks rising or falling edges. Software disarms the counter, writes the load values, issues a load, and then arms it. A trigger starts counting. Each time the count is zero on an enabled edge, the block pulses `tc` for one cycle and reloads. All pins are plain control and status signals. No data stream crosses the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `upd_ivl_counter`

## Requirements
- R1: After reset the counter is disarmed, `count` is 0, `tc` is low, the primary value is selected and no one-shot switch request is pending.
- R2: While disarmed, a `load_cmd` strobe copies the selected load value into `count` by the next cycle. While armed, `load_cmd` has no effect on `count`.
- R3: With `src_falling` = 0 the counter advances on rising edges of `src_in`. With `src_falling` = 1 it advances on falling edges. The other edge has no effect.
- R4: While running, each enabled edge lowers a non-zero count by one. An edge at count zero raises `tc` for exactly one cycle, so a period loaded with N spans N+1 edges.
- R5: On the edge that raises `tc`, the count takes the value of the selected load register, with no extra cycle.
- R6: Arming moves the counter to a wait state in which edges are ignored. A `trigger` then starts counting. `disarm` returns it to the disarmed state and freezes `count`.
- R7: Mode code 0 (fixed) never changes the selection.
- R8: Mode code 1 (alternate on stop): a `stop_evt` selects the secondary value for exactly one reload, and every later reload uses the primary value.
- R9: Mode code 3 (alternate on buffer end) behaves as R8 but responds to `bctc_evt`.
- R10: Mode codes 2 and 4 toggle the selection on every `stop_evt` or `bctc_evt` respectively. Mode codes that do not name an event ignore that event.
- R11: Mode codes 5, 6 and 7 toggle the selection once, on the next `bctc_evt`, `stop_evt` or terminal count respectively. The toggle needs a prior `switch_req` strobe, and it consumes that request. Without a pending request the event has no effect.
- R12: In modes 1 and 3, every `trigger` while armed loads the secondary value at once and selects the primary value for later reloads.
- R13: A reload uses the selection held before its cycle. An event in the same cycle as `tc` changes the selection only for later reloads, and in alternate modes the event wins over the return to primary.
- R14: The load values may be written in any state, and a write takes effect at the next load or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 1 | Selected source level to be edge-counted |
| src_falling | input | 1 | 0: count rising edges, 1: count falling edges |
| arm | input | 1 | Strobe: leave disarmed state and wait for trigger |
| disarm | input | 1 | Strobe: stop and return to disarmed state |
| load_cmd | input | 1 | Strobe: load selected value while disarmed |
| trigger | input | 1 | Start counting; retrigger in alternate modes |
| stop_evt | input | 1 | Stop event pulse |
| bctc_evt | input | 1 | Buffer-complete event pulse |
| sel_mode | input | 3 | Selection policy code (0..7, see R7-R11) |
| switch_req | input | 1 | Strobe arming a one-shot switch |
| pri_wr | input | 1 | Write `wr_data` to the primary load value |
| sec_wr | input | 1 | Write `wr_data` to the secondary load value |
| wr_data | input | CNT_W | Load value write data |
| tc | output | 1 | Terminal count pulse |
| count | output | CNT_W | Current count |

## Verification
The case that needs care is a stop event that lands in the same cycle as the terminal-count reload in alternate-on-stop mode. The bench provokes it by raising `stop_evt` in the one cycle when the source edge is pending at count zero. It does this twice: once with the primary value selected and once with the secondary already selected. In each case the bench judges the result from the value reloaded on that edge and the values reloaded on the two terminal counts that follow.

// File: rtl/upd_ivl_pkg.sv
package upd_ivl_pkg;

  typedef enum logic [2:0] {
    SEL_FIXED     = 3'd0,
    SEL_ALT_STOP  = 3'd1,
    SEL_TOG_STOP  = 3'd2,
    SEL_ALT_BC    = 3'd3,
    SEL_TOG_BC    = 3'd4,
    SEL_ONCE_BC   = 3'd5,
    SEL_ONCE_STOP = 3'd6,
    SEL_ONCE_TC   = 3'd7
  } sel_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } run_state_e;

endpackage

// File: rtl/upd_ivl_edge.sv
module upd_ivl_edge #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic src_falling,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= src_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], src_in};
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign edge_o = src_falling ? (prev_q & ~cur) : (~prev_q & cur);

  // R3: an edge of one polarity cannot repeat on the next cycle
  assert_edge_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || (src_falling != $past(src_falling))));

  // R3: the level left after a counted edge matches the chosen direction
  assert_edge_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (prev_q == !$past(src_falling)));

endmodule

// File: rtl/upd_ivl_select.sv
module upd_ivl_select
  import upd_ivl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_raw,
  input  logic       stop_evt,
  input  logic       bctc_evt,
  input  logic       tc_evt,
  input  logic       tc_reload,
  input  logic       trig_ld,
  input  logic       switch_req,
  output logic       sel_sec
);

  sel_mode_e mode;
  logic      sel_q, sel_d;
  logic      pend_q, pend_d;

  assign mode = sel_mode_e'(mode_raw);

  always_comb begin
    sel_d  = sel_q;
    pend_d = pend_q | switch_req;
    case (mode)
      SEL_ALT_STOP: begin
        if (stop_evt)                sel_d = 1'b1;
        else if (trig_ld)            sel_d = 1'b0;
        else if (tc_reload && sel_q) sel_d = 1'b0;
      end
      SEL_ALT_BC: begin
        if (bctc_evt)                sel_d = 1'b1;
        else if (trig_ld)            sel_d = 1'b0;
        else if (tc_reload && sel_q) sel_d = 1'b0;
      end
      SEL_TOG_STOP: if (stop_evt) sel_d = ~sel_q;
      SEL_TOG_BC:   if (bctc_evt) sel_d = ~sel_q;
      SEL_ONCE_BC: begin
        if (pend_q && bctc_evt) begin
          sel_d  = ~sel_q;
          pend_d = switch_req;
        end
      end
      SEL_ONCE_STOP: begin
        if (pend_q && stop_evt) begin
          sel_d  = ~sel_q;
          pend_d = switch_req;
        end
      end
      SEL_ONCE_TC: begin
        if (pend_q && tc_evt) begin
          sel_d  = ~sel_q;
          pend_d = switch_req;
        end
      end
      default: sel_d = sel_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      pend_q <= pend_d;
    end
  end

  assign sel_sec = sel_q;

  // R7: the fixed policy never moves the selection
  assert_fixed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_FIXED) |=> $stable(sel_q));

  // R10: every stop toggles under the toggle-on-stop policy
  assert_tog_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_TOG_STOP && stop_evt) |=> (sel_q != $past(sel_q)));

  // R8: one secondary reload, then back to primary
  assert_alt_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_ALT_STOP && tc_reload && sel_q && !stop_evt) |=> !sel_q);

  // R11: a consumed one-shot request is cleared
  assert_once_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_ONCE_STOP && pend_q && stop_evt && !switch_req) |=> !pend_q);

endmodule

// File: rtl/upd_ivl_core.sv
module upd_ivl_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             force_ld,
  input  logic [CNT_W-1:0] force_val,
  input  logic [CNT_W-1:0] rld_val,
  output logic             tc_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             zero;

  assign zero = (cnt_q == '0);
  assign tc_o = cnt_en & zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (force_ld) cnt_q <= force_val;
    else if (cnt_en)  cnt_q <= zero ? rld_val : (cnt_q - STEP);
  end

  assign cnt_o = cnt_q;

  // R4: terminal count lasts one cycle
  assert_tc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o);

  // R4: a non-zero count steps down by one per enabled edge
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !zero && !force_ld) |=> (cnt_q == $past(cnt_q) - STEP));

  // R5: terminal count reloads from the selected value at once
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && !force_ld) |=> (cnt_q == $past(rld_val)));

endmodule

// File: rtl/upd_ivl_counter.sv
module upd_ivl_counter
  import upd_ivl_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_in,
  input  logic             src_falling,
  input  logic             arm,
  input  logic             disarm,
  input  logic             load_cmd,
  input  logic             trigger,
  input  logic             stop_evt,
  input  logic             bctc_evt,
  input  logic [2:0]       sel_mode,
  input  logic             switch_req,
  input  logic             pri_wr,
  input  logic             sec_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             tc,
  output logic [CNT_W-1:0] count
);

  run_state_e       st_q;
  logic [CNT_W-1:0] pri_q, sec_q;
  logic [CNT_W-1:0] sel_val, force_val;
  logic             sel_sec;
  logic             src_edge, cnt_en;
  logic             alt_mode, trig_ld, idle_ld, force_ld;

  // load value registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (pri_wr) pri_q <= wr_data;
      if (sec_wr) sec_q <= wr_data;
    end
  end

  // arm / trigger state
  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= ST_IDLE;
    else if (disarm) st_q <= ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (arm)     st_q <= ST_WAIT;
        ST_WAIT: if (trigger) st_q <= ST_RUN;
        default:              st_q <= ST_RUN;
      endcase
    end
  end

  assign alt_mode  = (sel_mode == SEL_ALT_STOP) || (sel_mode == SEL_ALT_BC);
  assign trig_ld   = trigger & ~disarm & (st_q != ST_IDLE) & alt_mode;
  assign idle_ld   = load_cmd & (st_q == ST_IDLE);
  assign force_ld  = idle_ld | trig_ld;
  assign sel_val   = sel_sec ? sec_q : pri_q;
  assign force_val = trig_ld ? sec_q : sel_val;
  assign cnt_en    = src_edge & (st_q == ST_RUN);

  upd_ivl_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_in      (src_in),
    .src_falling (src_falling),
    .edge_o      (src_edge)
  );

  upd_ivl_select u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_raw   (sel_mode),
    .stop_evt   (stop_evt),
    .bctc_evt   (bctc_evt),
    .tc_evt     (tc),
    .tc_reload  (tc & ~trig_ld),
    .trig_ld    (trig_ld),
    .switch_req (switch_req),
    .sel_sec    (sel_sec)
  );

  upd_ivl_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .force_ld  (force_ld),
    .force_val (force_val),
    .rld_val   (sel_val),
    .tc_o      (tc),
    .cnt_o     (count)
  );

  // R6: disarm always lands in the disarmed state
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> (st_q == ST_IDLE));

  // R6: nothing but a load moves the count while disarmed
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !load_cmd) |=> $stable(count));

  // R2: a disarmed load copies the value selected in that cycle
  assert_idle_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && load_cmd) |=> (count == $past(sel_sec ? sec_q : pri_q)));

endmodule

// File: tb/upd_ivl_counter_bench.sv
module upd_ivl_counter_bench;

  localparam int W = 24;
  localparam int NROW = 11;
  localparam logic [W-1:0] PV = 24'd3;
  localparam logic [W-1:0] SV = 24'd5;

  // row: [9:7] mode, [6:5] event (0 none, 1 stop, 2 buffer end), [4] switch
  // request, [3:0] secondary-used flag for reloads 3..0 (bit0 = first reload)
  localparam logic [9:0] VEC [NROW] = '{
    {3'd0, 2'd1, 1'b0, 4'b0000},
    {3'd1, 2'd1, 1'b0, 4'b0001},
    {3'd2, 2'd1, 1'b0, 4'b1111},
    {3'd3, 2'd2, 1'b0, 4'b0001},
    {3'd4, 2'd2, 1'b0, 4'b1111},
    {3'd5, 2'd2, 1'b1, 4'b1111},
    {3'd6, 2'd1, 1'b1, 4'b1111},
    {3'd7, 2'd0, 1'b1, 4'b1110},
    {3'd1, 2'd2, 1'b0, 4'b0000},
    {3'd2, 2'd2, 1'b0, 4'b0000},
    {3'd5, 2'd2, 1'b0, 4'b0000}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, src_in, src_falling, arm, disarm, load_cmd, trigger;
  logic         stop_evt, bctc_evt, switch_req, pri_wr, sec_wr, tc;
  logic [2:0]   sel_mode;
  logic [W-1:0] wr_data, count;

  upd_ivl_counter u_upd_ivl_counter (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_falling(src_falling),
    .arm(arm), .disarm(disarm), .load_cmd(load_cmd), .trigger(trigger),
    .stop_evt(stop_evt), .bctc_evt(bctc_evt), .sel_mode(sel_mode),
    .switch_req(switch_req), .pri_wr(pri_wr), .sec_wr(sec_wr),
    .wr_data(wr_data), .tc(tc), .count(count)
  );

  int checks = 0;
  int fails = 0;
  int tc_count = 0;
  int tc_double = 0;
  logic tc_prev = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (tc && tc_prev) tc_double++;
    if (tc) tc_count++;
    tc_prev = tc;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 arm, 1 disarm, 2 load, 3 trigger, 4 stop, 5 buffer end, 6 switch request
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: arm = 1'b1;
      1: disarm = 1'b1;
      2: load_cmd = 1'b1;
      3: trigger = 1'b1;
      4: stop_evt = 1'b1;
      5: bctc_evt = 1'b1;
      default: switch_req = 1'b1;
    endcase
    @(negedge clk);
    {arm, disarm, load_cmd, trigger, stop_evt, bctc_evt, switch_req} = '0;
  endtask

  task automatic write_val(input bit sec, input logic [W-1:0] v);
    @(negedge clk);
    wr_data = v;
    if (sec) sec_wr = 1'b1; else pri_wr = 1'b1;
    @(negedge clk);
    pri_wr = 1'b0;
    sec_wr = 1'b0;
  endtask

  task automatic tick();
    src_in = 1'b1;
    repeat (2) @(negedge clk);
    src_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // stop pulse placed on the same edge that applies the rising source edge
  task automatic tick_with_stop();
    src_in = 1'b1;
    @(negedge clk);
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    src_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_to_tc();
    int start;
    start = tc_count;
    for (int i = 0; i < 40 && tc_count == start; i++) tick();
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    {src_in, src_falling, arm, disarm, load_cmd, trigger} = '0;
    {stop_evt, bctc_evt, switch_req, pri_wr, sec_wr} = '0;
    sel_mode = 3'd0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R7";
      3'd1: return "R8";
      3'd3: return "R9";
      3'd2, 3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0;
    apply_reset();
    check("R1 count after reset", count, '0);
    check("R1 tc after reset", W'(tc), '0);

    // R1 primary selected; R2 disarmed load
    write_val(1'b0, 24'd9);
    write_val(1'b1, 24'd4);
    strobe(2);
    check("R2 disarmed load takes primary", count, 24'd9);

    // R2 load ignored while armed; R14 write accepted while armed
    strobe(0);
    write_val(1'b0, 24'd12);
    strobe(2);
    check("R2 load ignored when armed", count, 24'd9);

    // R6 waiting for trigger ignores edges
    tick();
    check("R6 no count before trigger", count, 24'd9);
    strobe(3);
    tick();
    check("R4 step down", count, 24'd8);

    // R3 polarity
    src_in = 1'b1; repeat (2) @(negedge clk);
    check("R3 rising counted", count, 24'd7);
    src_in = 1'b0; repeat (2) @(negedge clk);
    check("R3 falling ignored", count, 24'd7);
    src_falling = 1'b1;
    src_in = 1'b1; repeat (2) @(negedge clk);
    check("R3 rising ignored in falling mode", count, 24'd7);
    src_in = 1'b0; repeat (2) @(negedge clk);
    check("R3 falling counted", count, 24'd6);
    src_falling = 1'b0;
    @(negedge clk);

    // R4 period length; R5 / R14 reload picks up value written while armed
    t0 = tc_count;
    repeat (6) tick();
    check("R4 count reaches zero", count, '0);
    check("R4 no tc before zero edge", W'(tc_count - t0), '0);
    tick();
    check("R4 one tc at zero edge", W'(tc_count - t0), 24'd1);
    check("R14 R5 reload uses newly written primary", count, 24'd12);
    check("R4 tc never two cycles", W'(tc_double), '0);

    // R6 disarm freezes the count
    strobe(1);
    tick();
    check("R6 disarm freezes count", count, 24'd12);

    // R12 retrigger in alternate mode
    apply_reset();
    sel_mode = 3'd1;
    write_val(1'b0, PV);
    write_val(1'b1, SV);
    strobe(2);
    strobe(0);
    strobe(3);
    check("R12 trigger loads secondary", count, SV);
    tick(); tick();
    check("R12 counting after trigger", count, 24'd3);
    strobe(3);
    check("R12 retrigger loads secondary", count, SV);
    run_to_tc();
    check("R12 primary after first period", count, PV);

    // R13 stop on the terminal count edge, primary selected
    repeat (3) tick();
    t0 = tc_count;
    tick_with_stop();
    check("R13 collision tc seen", W'(tc_count - t0), 24'd1);
    check("R13 collision reload uses prior primary", count, PV);
    run_to_tc();
    check("R13 event applies to next reload", count, SV);
    run_to_tc();
    check("R13 back to primary", count, PV);

    // R13 stop on the terminal count edge, secondary already selected
    strobe(4);
    repeat (3) tick();
    tick_with_stop();
    check("R13 collision reload uses secondary", count, SV);
    run_to_tc();
    check("R13 event wins over return to primary", count, SV);
    run_to_tc();
    check("R13 primary after the extra secondary", count, PV);

    // table walk over selection policies
    for (int r = 0; r < NROW; r++) begin
      logic [9:0] v;
      v = VEC[r];
      apply_reset();
      sel_mode = v[9:7];
      write_val(1'b0, PV);
      write_val(1'b1, SV);
      strobe(2);
      strobe(0);
      if (v[4]) strobe(6);
      strobe(3);
      if (v[6:5] == 2'd1) strobe(4);
      else if (v[6:5] == 2'd2) strobe(5);
      for (int k = 0; k < 4; k++) begin
        run_to_tc();
        check($sformatf("%s row %0d reload %0d", req_of(v[9:7]), r, k),
              count, v[k] ? SV : PV);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule